// File: doc/BRIEF.md
# Reversible Gate Cascade with Fault Injection

This block evaluates a classical reversible circuit on basis-state vectors. The circuit is an ordered list of generalized controlled-NOT gates on a set of wires. Each gate is held in a configuration table as a control mask, a target wire index and an enable bit. Evaluation starts with a start pulse that captures an input vector. The block then applies one gate per clock, from gate 0 up to the last gate, and raises a done pulse when the last gate has been applied.

Two datapaths run side by side. One evaluates the circuit as configured. The other evaluates it with one selected fault applied. The fault choices are:

- no fault;
- one gate left out;
- one gate repeated a given number of times;
- a contiguous run of gates left out;
- some control inputs removed from one gate.

Both results are available in the same cycle, together with a flag that says whether they differ. This lets a test flow decide, vector by vector, whether an input pattern exposes the injected fault.

Top module: `revgate_cascade`

## Requirements
- R1: A gate leaves every wire except its target unchanged. It inverts the target wire exactly when every wire set in its effective control mask is 1. The effective mask is the configured mask with the target's own bit cleared, so an empty effective mask makes the gate a plain inverter. Wire i is bit i of the vector.
- R2: A start accepted while idle raises busy on the next cycle. Gates 0 to N_GATES-1 are then applied one per clock, in index order. In the cycle after the edge that applies the last gate, busy is low and done is high for exactly one cycle.
- R3: A table entry whose enable bit is 0 leaves the vector unchanged in both datapaths.
- R4: With fault mode 0 (none), the faulty result equals the fault-free result.
- R5: Fault mode 1 (missing) leaves out gate `flt_lo` in the faulty datapath only.
- R6: Fault mode 2 (repeated) replaces gate `flt_lo` by `flt_reps` copies in the faulty datapath. An even count, including zero, acts as a missing gate. An odd count acts as the fault-free gate.
- R7: Fault mode 3 (range) leaves out every gate with index from `flt_lo` to `flt_hi` inclusive in the faulty datapath. If `flt_lo` is greater than `flt_hi`, no gate is left out.
- R8: Fault mode 4 (partial) clears the bits of `flt_drop` from the control mask of gate `flt_lo` in the faulty datapath. Clearing all of its controls turns it into an inverter.
- R9: A start while busy is ignored. A table write while busy is ignored.
- R10: After reset, both outputs are zero, busy and done are low, and every table entry is disabled.
- R11: `mismatch` is high exactly when the two outputs differ. Both outputs hold their last result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | GIW | Table entry to write |
| cfg_mask | input | N_WIRES | Control mask of the written gate |
| cfg_tgt | input | WIW | Target wire of the written gate |
| cfg_en | input | 1 | Enable bit of the written gate |
| flt_mode | input | 3 | Fault mode: 0 none, 1 missing, 2 repeated, 3 range, 4 partial |
| flt_lo | input | GIW | Selected gate, or first gate of a range |
| flt_hi | input | GIW | Last gate of a range |
| flt_reps | input | REP_W | Copy count for the repeated mode |
| flt_drop | input | N_WIRES | Control bits removed in the partial mode |
| start | input | 1 | Captures vec_in and the fault settings, then begins evaluation |
| vec_in | input | N_WIRES | Input vector |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| good_out | output | N_WIRES | Fault-free result |
| bad_out | output | N_WIRES | Faulty result |
| mismatch | output | 1 | Results differ |

## Verification
The bench builds the block with 4 wires and 4 gates. With these values, the three-gate example (input 1010 to output 1100) fits in the table, with one spare entry for inverter, disabled-gate and mask-on-target cases. Every one of the 16 input vectors can be swept under each fault mode. Ranges that cover the first or last gate, and an inverted range, are all reachable. With four gates, the start-to-done window is short enough that mid-run starts and table writes can be placed at chosen cycles.

// File: rtl/revgate_pkg.sv
package revgate_pkg;
  typedef enum logic [2:0] {
    FM_NONE    = 3'd0,
    FM_MISSING = 3'd1,
    FM_REPEAT  = 3'd2,
    FM_RANGE   = 3'd3,
    FM_PARTIAL = 3'd4
  } fault_mode_e;
endpackage

// File: rtl/revgate_table.sv
module revgate_table #(
  parameter int N_WIRES = 8,
  parameter int N_GATES = 8,
  localparam int GIW = (N_GATES > 1) ? $clog2(N_GATES) : 1,
  localparam int WIW = (N_WIRES > 1) ? $clog2(N_WIRES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [GIW-1:0]     wr_idx,
  input  logic [N_WIRES-1:0] wr_mask,
  input  logic [WIW-1:0]     wr_tgt,
  input  logic               wr_on,
  input  logic [GIW-1:0]     rd_idx,
  output logic [N_WIRES-1:0] rd_mask,
  output logic [WIW-1:0]     rd_tgt,
  output logic               rd_on
);
  logic [N_WIRES-1:0] mask_q [N_GATES];
  logic [WIW-1:0]     tgt_q  [N_GATES];
  logic               on_q   [N_GATES];

  for (genvar g = 0; g < N_GATES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == GIW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= '0;
        tgt_q[g]  <= '0;
        on_q[g]   <= 1'b0;
      end else if (sel) begin
        mask_q[g] <= wr_mask;
        tgt_q[g]  <= wr_tgt;
        on_q[g]   <= wr_on;
      end
    end
  end

  always_comb begin
    rd_mask = mask_q[rd_idx];
    rd_tgt  = tgt_q[rd_idx];
    rd_on   = on_q[rd_idx];
  end
endmodule

// File: rtl/revgate_fault_sel.sv
module revgate_fault_sel
  import revgate_pkg::*;
#(
  parameter int N_WIRES = 8,
  parameter int N_GATES = 8,
  localparam int GIW = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
  input  fault_mode_e        mode,
  input  logic [GIW-1:0]     lo,
  input  logic [GIW-1:0]     hi,
  input  logic               reps_odd,
  input  logic [N_WIRES-1:0] drop,
  input  logic [GIW-1:0]     idx,
  input  logic [N_WIRES-1:0] mask_in,
  input  logic               on_in,
  output logic [N_WIRES-1:0] mask_out,
  output logic               on_out
);
  logic hit;
  assign hit = (idx == lo);

  always_comb begin
    mask_out = mask_in;
    on_out   = on_in;
    unique case (mode)
      FM_MISSING: if (hit) on_out = 1'b0;
      FM_REPEAT:  if (hit && !reps_odd) on_out = 1'b0;
      FM_RANGE:   if (idx >= lo && idx <= hi) on_out = 1'b0;
      FM_PARTIAL: if (hit) mask_out = mask_in & ~drop;
      default:    ;
    endcase
  end
endmodule

// File: rtl/revgate_apply.sv
module revgate_apply #(
  parameter int N_WIRES = 8,
  localparam int WIW = (N_WIRES > 1) ? $clog2(N_WIRES) : 1
) (
  input  logic [N_WIRES-1:0] vec,
  input  logic [N_WIRES-1:0] mask,
  input  logic [WIW-1:0]     tgt,
  input  logic               on,
  output logic [N_WIRES-1:0] vec_nx
);
  logic [N_WIRES-1:0] tbit;
  logic [N_WIRES-1:0] ctl;
  logic               fire;

  always_comb begin
    tbit   = N_WIRES'(1) << tgt;
    ctl    = mask & ~tbit;
    fire   = on && ((vec & ctl) == ctl);
    vec_nx = fire ? (vec ^ tbit) : vec;
  end
endmodule

// File: rtl/revgate_seq.sv
module revgate_seq #(
  parameter int N_GATES = 8,
  localparam int GIW = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic [GIW-1:0] idx,
  output logic           load,
  output logic           step
);
  localparam logic [GIW-1:0] LAST = GIW'(N_GATES - 1);

  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic [GIW-1:0] idx_q, idx_d;

  always_comb begin
    load   = start && !busy_q;
    step   = busy_q;
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign idx  = idx_q;
endmodule

// File: rtl/revgate_cascade.sv
module revgate_cascade
  import revgate_pkg::*;
#(
  parameter int N_WIRES = 8,
  parameter int N_GATES = 8,
  parameter int REP_W   = 4,
  localparam int GIW = (N_GATES > 1) ? $clog2(N_GATES) : 1,
  localparam int WIW = (N_WIRES > 1) ? $clog2(N_WIRES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [GIW-1:0]     cfg_idx,
  input  logic [N_WIRES-1:0] cfg_mask,
  input  logic [WIW-1:0]     cfg_tgt,
  input  logic               cfg_en,
  input  logic [2:0]         flt_mode,
  input  logic [GIW-1:0]     flt_lo,
  input  logic [GIW-1:0]     flt_hi,
  input  logic [REP_W-1:0]   flt_reps,
  input  logic [N_WIRES-1:0] flt_drop,
  input  logic               start,
  input  logic [N_WIRES-1:0] vec_in,
  output logic               busy,
  output logic               done,
  output logic [N_WIRES-1:0] good_out,
  output logic [N_WIRES-1:0] bad_out,
  output logic               mismatch
);
  logic           load, step;
  logic [GIW-1:0] idx;

  revgate_seq #(.N_GATES(N_GATES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .idx(idx), .load(load), .step(step)
  );

  logic [N_WIRES-1:0] g_mask;
  logic [WIW-1:0]     g_tgt;
  logic               g_on;

  revgate_table #(.N_WIRES(N_WIRES), .N_GATES(N_GATES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && !busy), .wr_idx(cfg_idx), .wr_mask(cfg_mask),
    .wr_tgt(cfg_tgt), .wr_on(cfg_en),
    .rd_idx(idx), .rd_mask(g_mask), .rd_tgt(g_tgt), .rd_on(g_on)
  );

  // fault settings captured with the input vector
  fault_mode_e        flt_mode_q;
  logic [GIW-1:0]     flt_lo_q, flt_hi_q;
  logic               flt_odd_q;
  logic [N_WIRES-1:0] flt_drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_mode_q <= FM_NONE;
      flt_lo_q   <= '0;
      flt_hi_q   <= '0;
      flt_odd_q  <= 1'b0;
      flt_drop_q <= '0;
    end else if (load) begin
      flt_mode_q <= fault_mode_e'(flt_mode);
      flt_lo_q   <= flt_lo;
      flt_hi_q   <= flt_hi;
      flt_odd_q  <= flt_reps[0];
      flt_drop_q <= flt_drop;
    end
  end

  logic [N_WIRES-1:0] f_mask;
  logic               f_on;

  revgate_fault_sel #(.N_WIRES(N_WIRES), .N_GATES(N_GATES)) u_fsel (
    .mode(flt_mode_q), .lo(flt_lo_q), .hi(flt_hi_q), .reps_odd(flt_odd_q),
    .drop(flt_drop_q), .idx(idx), .mask_in(g_mask), .on_in(g_on),
    .mask_out(f_mask), .on_out(f_on)
  );

  logic [N_WIRES-1:0] good_q, bad_q, good_nx, bad_nx;

  revgate_apply #(.N_WIRES(N_WIRES)) u_good (
    .vec(good_q), .mask(g_mask), .tgt(g_tgt), .on(g_on), .vec_nx(good_nx)
  );
  revgate_apply #(.N_WIRES(N_WIRES)) u_bad (
    .vec(bad_q), .mask(f_mask), .tgt(g_tgt), .on(f_on), .vec_nx(bad_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= '0;
    end else if (load) begin
      good_q <= vec_in;
      bad_q  <= vec_in;
    end else if (step) begin
      good_q <= good_nx;
      bad_q  <= bad_nx;
    end
  end

  assign good_out = good_q;
  assign bad_out  = bad_q;
  assign mismatch = (good_q != bad_q);
endmodule

// File: rtl/revgate_cascade_chk.sv
module revgate_cascade_chk #(
  parameter int N_WIRES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [N_WIRES-1:0] good_out,
  input logic [N_WIRES-1:0] bad_out,
  input logic [2:0]         mode_q
);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_start_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(good_out) && $stable(bad_out)));

  p_clean_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == 3'd0) |-> (good_out == bad_out));
endmodule

bind revgate_cascade revgate_cascade_chk #(.N_WIRES(N_WIRES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .good_out(good_out), .bad_out(bad_out), .mode_q(flt_mode_q)
);

// File: tb/revgate_cascade_bench.sv
`timescale 1ns/1ps
module revgate_cascade_bench;
  localparam int NW = 4;
  localparam int NG = 4;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic [NW-1:0] cfg_mask = '0;
  logic [1:0]    cfg_tgt = '0;
  logic          cfg_en = 1'b0;
  logic [2:0]    flt_mode = '0;
  logic [1:0]    flt_lo = '0, flt_hi = '0;
  logic [RW-1:0] flt_reps = '0;
  logic [NW-1:0] flt_drop = '0;
  logic          start = 1'b0;
  logic [NW-1:0] vec_in = '0;
  logic          busy, done, mismatch;
  logic [NW-1:0] good_out, bad_out;

  revgate_cascade #(.N_WIRES(NW), .N_GATES(NG), .REP_W(RW)) u_revgate_cascade (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_mask(cfg_mask), .cfg_tgt(cfg_tgt), .cfg_en(cfg_en),
    .flt_mode(flt_mode), .flt_lo(flt_lo), .flt_hi(flt_hi),
    .flt_reps(flt_reps), .flt_drop(flt_drop), .start(start),
    .vec_in(vec_in), .busy(busy), .done(done), .good_out(good_out),
    .bad_out(bad_out), .mismatch(mismatch)
  );

  int checks = 0;
  int errors = 0;

  // bench copy of the gate table
  int bmask [NG];
  int btgt  [NG];
  bit ben   [NG];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ref_eval(input int v, input int mode, input int lo,
                                  input int hi, input int reps, input int drop,
                                  input bit faulty);
    int s = v;
    for (int g = 0; g < NG; g++) begin
      int m = bmask[g];
      bit on = ben[g];
      int copies = 1;
      if (faulty) begin
        if (mode == 1 && g == lo) copies = 0;
        if (mode == 2 && g == lo) copies = reps;
        if (mode == 3 && g >= lo && g <= hi) copies = 0;
        if (mode == 4 && g == lo) m = m & ~drop;
      end
      m = m & ~(1 << btgt[g]);
      for (int c = 0; c < copies; c++)
        if (on && ((s & m) == m)) s = s ^ (1 << btgt[g]);
    end
    return s;
  endfunction

  task automatic write_gate(input int g, input int m, input int t, input bit e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(g); cfg_mask = NW'(m); cfg_tgt = 2'(t); cfg_en = e;
    @(negedge clk);
    cfg_we = 1'b0;
    bmask[g] = m; btgt[g] = t; ben[g] = e;
  endtask

  // runs one evaluation, checking busy/done every cycle and results at done
  task automatic run(input int v, input int mode, input int lo, input int hi,
                     input int reps, input int drop, input string req,
                     input bit disturb);
    int eg, eb;
    eg = ref_eval(v, mode, lo, hi, reps, drop, 1'b0);
    eb = ref_eval(v, mode, lo, hi, reps, drop, 1'b1);
    @(negedge clk);
    vec_in = NW'(v); flt_mode = 3'(mode); flt_lo = 2'(lo); flt_hi = 2'(hi);
    flt_reps = RW'(reps); flt_drop = NW'(drop); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R2 busy after start", {busy, done}, 2'b10);
    for (int j = 1; j <= NG; j++) begin
      if (disturb && j == 1) begin
        // R9: a start and a table write while busy must both be ignored
        start = 1'b1; vec_in = ~NW'(v); flt_mode = 3'd1;
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_mask = '0; cfg_tgt = 2'd3; cfg_en = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
      chk(done === (j == NG) && busy === (j < NG), "R2 busy/done timing",
          {busy, done}, {(j < NG), (j == NG)});
    end
    chk(good_out === NW'(eg), {req, " good_out"}, good_out, eg);
    chk(bad_out === NW'(eb), {req, " bad_out"}, bad_out, eb);
    chk(mismatch === (eg != eb), "R11 mismatch flag", mismatch, (eg != eb));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int g = 0; g < NG; g++) begin bmask[g] = 0; btgt[g] = 0; ben[g] = 0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy === 1'b0 && done === 1'b0, "R10 busy/done at reset", {busy, done}, 0);
    chk(good_out === '0 && bad_out === '0, "R10 outputs at reset", {good_out, bad_out}, 0);
    rst_n = 1'b1;
    // R10/R3: empty table leaves vector unchanged
    run('b1010, 0, 0, 0, 0, 0, "R10 R3 empty table", 0);
    chk(good_out === 4'b1010, "R10 untouched vector", good_out, 4'b1010);

    // three-gate example; wire a=bit3, b=bit2, c=bit1, d=bit0
    write_gate(0, 'b1010, 2, 1);
    write_gate(1, 'b0100, 1, 1);
    write_gate(2, 'b1110, 0, 1);
    run('b1010, 0, 0, 0, 0, 0, "R1 R4 example", 0);
    chk(good_out === 4'b1100, "R1 example result 1100", good_out, 4'b1100);

    // R5 missing gate
    run('b1010, 1, 0, 0, 0, 0, "R5 missing gate 0", 0);
    chk(bad_out === 4'b1010 && mismatch, "R5 fault exposed", bad_out, 4'b1010);
    run('b1111, 1, 2, 0, 0, 0, "R5 missing gate 2", 0);
    // R6 repeated
    run('b1010, 2, 0, 0, 2, 0, "R6 even copies", 0);
    run('b1010, 2, 0, 0, 3, 0, "R6 odd copies", 0);
    run('b1110, 2, 2, 0, 0, 0, "R6 zero copies", 0);
    // R7 range
    run('b1010, 3, 1, 2, 0, 0, "R7 range 1..2", 0);
    run('b1010, 3, 0, 3, 0, 0, "R7 full range", 0);
    run('b1010, 3, 2, 1, 0, 0, "R7 inverted range", 0);
    chk(!mismatch, "R7 inverted range removes nothing", mismatch, 0);
    // R8 partial
    run('b1011, 4, 2, 0, 0, 'b0010, "R8 drop one control", 0);
    run('b0000, 4, 2, 0, 0, 'b1110, "R8 drop all controls", 0);
    chk(bad_out === 4'b0001, "R8 becomes inverter", bad_out, 4'b0001);

    // R1: control mask that only names the target acts as an inverter
    write_gate(3, 'b0001, 0, 1);
    run('b0000, 0, 0, 0, 0, 0, "R1 mask on target ignored", 0);
    chk(good_out === 4'b0001, "R1 inverter gate", good_out, 4'b0001);
    // R3 disabled gate
    write_gate(1, 'b0100, 1, 0);
    run('b1010, 0, 0, 0, 0, 0, "R3 disabled gate", 0);
    // R9 start and table write while busy ignored
    run('b0110, 0, 0, 0, 0, 0, "R9 disturbed run", 1);
    run('b0000, 0, 0, 0, 0, 0, "R9 table unchanged", 0);
    chk(good_out === 4'b0001, "R9 gate 3 kept", good_out, 4'b0001);
    // R11 outputs hold while idle
    repeat (3) @(negedge clk);
    chk(good_out === 4'b0001 && bad_out === 4'b0001, "R11 hold", good_out, 4'b0001);

    // sweep all vectors under each fault mode
    write_gate(1, 'b0100, 1, 1);
    for (int v = 0; v < 16; v++) begin
      run(v, v % 5, v % 4, 3 - (v % 2), v % 3, v, "sweep", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule